// File: doc/BRIEF.md
# Bridge Transaction Forwarding Decoder

This block decides, for every transaction that appears on either side of a two-port bus bridge, whether the bridge claims it and in which direction it is passed on. A request carries an address, a transaction class (I/O, plain memory or prefetchable memory) and the side it came from. The decoder compares the address against three programmable windows, each bounded by an inclusive base and limit. It then applies command enable bits and returns a registered verdict one clock later.

A single set of windows serves both directions. Addresses inside a window belong to the secondary side, so primary-side requests that hit are forwarded downstream. Secondary-side requests that miss every window of their class are forwarded upstream. The address is never translated; the response echoes it unchanged.

Configuration is written through a small register port. All registers clear on reset, so nothing is forwarded until software enables it. The response stage is a two-state machine. The states are IDLE (no response pending) and RESP (a response is presented). The transitions are ACCEPT (IDLE to RESP on a request strobe), STREAM (RESP to RESP on a back-to-back request) and DRAIN (RESP to IDLE when no request arrives).

Top module: `bridge_fwd_decoder`

## Requirements
- R1: Every configuration register clears to zero on reset, and with reset values no request is claimed.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, so back-to-back requests give back-to-back responses. `rsp_claim` is never high without `rsp_valid`.
- R3: `rsp_addr` equals the address of the request it answers, unmodified, in both directions.
- R4: A window matches when base <= address <= limit on all 32 bits, with both ends inclusive. A window whose base exceeds its limit matches nothing.
- R5: A primary-side request (`req_side`=0) is claimed with `rsp_dir`=1 (downstream) when its class window holds the address. Class codes on `req_kind` are 0 = I/O (I/O window), 1 = memory (memory window) and 2 = prefetchable (prefetchable window).
- R6: A secondary-side request (`req_side`=1) is claimed with `rsp_dir`=0 (upstream) when its address is outside every window of its class. For I/O that is the I/O window. For memory and prefetchable it is both the memory and the prefetchable windows. A request inside such a window is not claimed.
- R7: With the I/O enable bit (command bit 0) clear, no primary-side I/O request is claimed.
- R8: With the memory enable bit (command bit 1) clear, no primary-side memory or prefetchable request is claimed.
- R9: With the master enable bit (command bit 2) clear, no secondary-side request is claimed. With it set, upstream claims for I/O and memory classes proceed per R6.
- R10: A configuration write takes effect on the following clock. A request presented in the same cycle as a write is decoded with the old values.
- R11: Class code 3 is reserved and is never claimed from either side.
- R12: When a response is not claimed, `rsp_dir` reads 0.
- R13: Register offsets on `cfg_addr` are 0 = command, 1/2 = I/O base/limit, 3/4 = memory base/limit and 5/6 = prefetchable base/limit. Other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_side | input | 1 | Origin: 0 primary, 1 secondary |
| req_kind | input | 2 | Class: 0 I/O, 1 memory, 2 prefetchable, 3 reserved |
| req_addr | input | 32 | Transaction address |
| rsp_valid | output | 1 | Response present |
| rsp_claim | output | 1 | Bridge claims and forwards the transaction |
| rsp_dir | output | 1 | 1 downstream, 0 upstream |
| rsp_addr | output | 32 | Address passed through unchanged |

## Verification
The bench probes both ends of each window and the addresses one below the base and one above the limit. An off-by-one comparator would claim or drop those edge addresses. It inverts a window so that base exceeds limit, where a decoder lacking the disable rule would claim everything or nothing in between. A memory request is placed inside the prefetchable window from the secondary side, which catches an upstream rule that tests only one memory window. A command write lands in the same cycle as a request, where a decoder that forwards the new value would refuse a request it should have claimed.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    localparam int ADDR_W  = 32;
    localparam int CFG_AW  = 3;
    localparam int NUM_WIN = 3;

    // window slots
    localparam int WIN_IO  = 0;
    localparam int WIN_MEM = 1;
    localparam int WIN_PF  = 2;

    // register offsets: command, then base/limit pairs per window
    localparam int REG_CMD  = 0;
    localparam int REG_WIN0 = 1;

    // command bit positions
    localparam int CMD_IO_BIT     = 0;
    localparam int CMD_MEM_BIT    = 1;
    localparam int CMD_MASTER_BIT = 2;

    typedef enum logic [1:0] {
        KIND_IO   = 2'd0,
        KIND_MEM  = 2'd1,
        KIND_PF   = 2'd2,
        KIND_RSVD = 2'd3
    } txn_kind_e;

    typedef enum logic {
        SIDE_PRI = 1'b0,
        SIDE_SEC = 1'b1
    } txn_side_e;

    typedef struct packed {
        logic master_en;
        logic mem_en;
        logic io_en;
    } cmd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/bfd_cfg_regs.sv
module bfd_cfg_regs
    import bfd_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CAW = CFG_AW,
    parameter int NW  = NUM_WIN
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CAW-1:0]         cfg_addr,
    input  logic [AW-1:0]          cfg_wdata,
    output cmd_t                   cmd,
    output logic [NW-1:0][AW-1:0]  win_base,
    output logic [NW-1:0][AW-1:0]  win_limit
);

    localparam logic [CAW-1:0] CMD_OFF = CAW'(REG_CMD);

    cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cfg_we && cfg_addr == CMD_OFF) begin
            cmd_q.io_en     <= cfg_wdata[CMD_IO_BIT];
            cmd_q.mem_en    <= cfg_wdata[CMD_MEM_BIT];
            cmd_q.master_en <= cfg_wdata[CMD_MASTER_BIT];
        end
    end

    assign cmd = cmd_q;

    for (genvar w = 0; w < NW; w++) begin : g_win
        localparam logic [CAW-1:0] BASE_OFF  = CAW'(REG_WIN0 + 2 * w);
        localparam logic [CAW-1:0] LIMIT_OFF = CAW'(REG_WIN0 + 2 * w + 1);

        logic [AW-1:0] base_q;
        logic [AW-1:0] limit_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= '0;
                limit_q <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == BASE_OFF)  base_q  <= cfg_wdata;
                if (cfg_addr == LIMIT_OFF) limit_q <= cfg_wdata;
            end
        end

        assign win_base[w]  = base_q;
        assign win_limit[w] = limit_q;
    end

endmodule

// File: rtl/bfd_window_match.sv
module bfd_window_match
    import bfd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WIN
) (
    input  logic [AW-1:0]          addr,
    input  logic [NW-1:0][AW-1:0]  win_base,
    input  logic [NW-1:0][AW-1:0]  win_limit,
    output logic [NW-1:0]          hit
);

    for (genvar w = 0; w < NW; w++) begin : g_cmp
        logic ordered;
        logic above_base;
        logic below_limit;

        // an inverted window (base past limit) is switched off
        assign ordered     = (win_base[w] <= win_limit[w]);
        assign above_base  = (addr >= win_base[w]);
        assign below_limit = (addr <= win_limit[w]);
        assign hit[w]      = ordered && above_base && below_limit;
    end

endmodule

// File: rtl/bfd_rsp_fsm.sv
module bfd_rsp_fsm
    import bfd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          claim_d,
    input  logic          dir_d,
    input  logic [AW-1:0] addr_d,
    output logic          rsp_valid,
    output logic          rsp_claim,
    output logic          rsp_dir,
    output logic [AW-1:0] rsp_addr
);

    rsp_state_e    state_q;
    rsp_state_e    state_d;
    logic          claim_q;
    logic          dir_q;
    logic [AW-1:0] addr_q;

    // next-state: ACCEPT, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_q <= 1'b0;
            dir_q   <= 1'b0;
            addr_q  <= '0;
        end else if (req_valid) begin
            claim_q <= claim_d;
            dir_q   <= claim_d && dir_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_claim = 1'b0;
        rsp_dir   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_claim = claim_q;
                rsp_dir   = dir_q;
            end
            default: ;
        endcase
    end

    assign rsp_addr = addr_q;

endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
    import bfd_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CAW = CFG_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic           req_valid,
    input  logic           req_side,
    input  logic [1:0]     req_kind,
    input  logic [AW-1:0]  req_addr,
    output logic           rsp_valid,
    output logic           rsp_claim,
    output logic           rsp_dir,
    output logic [AW-1:0]  rsp_addr
);

    cmd_t                      cmd_q;
    logic [NUM_WIN-1:0][AW-1:0] win_base;
    logic [NUM_WIN-1:0][AW-1:0] win_limit;
    logic [NUM_WIN-1:0]         hit;
    logic                       claim_d;
    logic                       dir_d;
    txn_kind_e                  kind;

    bfd_cfg_regs #(.AW(AW), .CAW(CAW), .NW(NUM_WIN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cmd       (cmd_q),
        .win_base  (win_base),
        .win_limit (win_limit)
    );

    bfd_window_match #(.AW(AW), .NW(NUM_WIN)) u_match (
        .addr      (req_addr),
        .win_base  (win_base),
        .win_limit (win_limit),
        .hit       (hit)
    );

    assign kind = txn_kind_e'(req_kind);

    // route decision: inside a window -> downstream, outside -> upstream
    always_comb begin
        claim_d = 1'b0;
        dir_d   = 1'b0;
        if (req_side == SIDE_PRI) begin
            unique case (kind)
                KIND_IO:  claim_d = cmd_q.io_en  && hit[WIN_IO];
                KIND_MEM: claim_d = cmd_q.mem_en && hit[WIN_MEM];
                KIND_PF:  claim_d = cmd_q.mem_en && hit[WIN_PF];
                default:  claim_d = 1'b0;
            endcase
            dir_d = 1'b1;
        end else begin
            unique case (kind)
                KIND_IO:  claim_d = cmd_q.master_en && !hit[WIN_IO];
                KIND_MEM,
                KIND_PF:  claim_d = cmd_q.master_en && !hit[WIN_MEM] && !hit[WIN_PF];
                default:  claim_d = 1'b0;
            endcase
            dir_d = 1'b0;
        end
    end

    bfd_rsp_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .claim_d   (claim_d),
        .dir_d     (dir_d),
        .addr_d    (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_claim (rsp_claim),
        .rsp_dir   (rsp_dir),
        .rsp_addr  (rsp_addr)
    );

endmodule

// File: rtl/bfd_chk.sv
module bfd_chk
    import bfd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_side,
    input logic [1:0]    req_kind,
    input logic [AW-1:0] req_addr,
    input cmd_t          cmd,
    input logic          rsp_valid,
    input logic          rsp_claim,
    input logic          rsp_dir,
    input logic [AW-1:0] rsp_addr
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    claim_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_claim |-> rsp_valid);

    // R3
    addr_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_addr == $past(req_addr));

    // R5
    pri_goes_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side == SIDE_PRI) |=> (!rsp_claim || rsp_dir));

    // R6
    sec_goes_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side == SIDE_SEC) |=> !rsp_dir);

    // R7
    io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side == SIDE_PRI && req_kind == KIND_IO && !cmd.io_en)
        |=> !rsp_claim);

    // R8
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side == SIDE_PRI && (req_kind == KIND_MEM || req_kind == KIND_PF)
         && !cmd.mem_en) |=> !rsp_claim);

    // R9
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side == SIDE_SEC && !cmd.master_en) |=> !rsp_claim);

    // R11
    rsvd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_RSVD) |=> !rsp_claim);

    // R12
    unclaimed_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_claim) |-> !rsp_dir);

endmodule

bind bridge_fwd_decoder bfd_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_side  (req_side),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .cmd       (cmd_q),
    .rsp_valid (rsp_valid),
    .rsp_claim (rsp_claim),
    .rsp_dir   (rsp_dir),
    .rsp_addr  (rsp_addr)
);

// File: tb/bridge_fwd_decoder_tb.sv
`timescale 1ns/1ps
module bridge_fwd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_side = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_claim;
    logic        rsp_dir;
    logic [31:0] rsp_addr;

    int errors = 0;
    int checks = 0;
    int pushed = 0;
    int seen   = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        claim;
        logic        dir;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t q[$];

    // shadow configuration kept by the bench
    logic [2:0]  sh_cmd;
    logic [31:0] sh_base [3];
    logic [31:0] sh_lim  [3];

    always #4 clk = ~clk;

    bridge_fwd_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_side  (req_side),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_claim (rsp_claim),
        .rsp_dir   (rsp_dir),
        .rsp_addr  (rsp_addr)
    );

    function automatic logic inside_win(int w, logic [31:0] a);
        return (sh_base[w] <= sh_lim[w]) && (a >= sh_base[w]) && (a <= sh_lim[w]);
    endfunction

    function automatic logic model_claim(logic side, logic [1:0] kind, logic [31:0] a);
        if (kind == 2'd3) return 1'b0;
        if (!side) begin
            if (kind == 2'd0) return sh_cmd[0] && inside_win(0, a);
            if (kind == 2'd1) return sh_cmd[1] && inside_win(1, a);
            return sh_cmd[1] && inside_win(2, a);
        end
        if (kind == 2'd0) return sh_cmd[2] && !inside_win(0, a);
        return sh_cmd[2] && !inside_win(1, a) && !inside_win(2, a);
    endfunction

    task automatic shadow_write(logic [2:0] off, logic [31:0] d);
        if (off == 3'd0) sh_cmd = d[2:0];
        else if (off <= 3'd6) begin
            if (off[0]) sh_base[(off - 1) / 2] = d;
            else        sh_lim[(off - 1) / 2]  = d;
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(logic side, logic [1:0] kind, logic [31:0] a, string tag);
        exp_t e;
        e.claim = model_claim(side, kind, a);
        e.dir   = e.claim && !side;
        e.addr  = a;
        e.tag   = tag;
        q.push_back(e);
        pushed++;
    endtask

    task automatic send(logic side, logic [1:0] kind, logic [31:0] a, string tag);
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = 1'b1;
        req_side  = side;
        req_kind  = kind;
        req_addr  = a;
        push_exp(side, kind, a, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_write(logic [2:0] off, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = off;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(off, d);
    endtask

    // R10: write and request in the same cycle
    task automatic write_and_send(logic [2:0] off, logic [31:0] d,
                                  logic side, logic [1:0] kind, logic [31:0] a, string tag);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = off;
        cfg_wdata = d;
        req_valid = 1'b1;
        req_side  = side;
        req_kind  = kind;
        req_addr  = a;
        push_exp(side, kind, a, tag);
        shadow_write(off, d);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            seen++;
            if (q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2: actual=unexpected response expected=none");
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " claim"}, {31'd0, rsp_claim}, {31'd0, e.claim});
                check({e.tag, " dir R12"}, {31'd0, rsp_dir}, {31'd0, e.dir});
                check({e.tag, " addr R3"}, rsp_addr, e.addr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        sh_cmd = '0;
        for (int i = 0; i < 3; i++) begin
            sh_base[i] = '0;
            sh_lim[i]  = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 reset rsp_claim", {31'd0, rsp_claim}, 32'd0);
        rst_n = 1'b1;

        // R1: reset values forward nothing
        send(1'b0, 2'd0, 32'h0000_0000, "R1 pri io at zero");
        send(1'b1, 2'd1, 32'h1234_5678, "R1 sec mem");
        send(1'b0, 2'd1, 32'h0000_0000, "R1 pri mem at zero");
        idle();

        // R13 map
        cfg_write(3'd1, 32'h0000_1000);
        cfg_write(3'd2, 32'h0000_1FFF);
        cfg_write(3'd3, 32'h8000_0000);
        cfg_write(3'd4, 32'h8FFF_FFFF);
        cfg_write(3'd5, 32'hC000_0000);
        cfg_write(3'd6, 32'hCFFF_FFFF);
        cfg_write(3'd7, 32'hFFFF_FFFF);   // R13 unused offset
        cfg_write(3'd0, 32'h0000_0007);

        // R4/R5 primary boundaries, back-to-back (R2)
        send(1'b0, 2'd0, 32'h0000_1000, "R4 io base inclusive");
        send(1'b0, 2'd0, 32'h0000_1FFF, "R4 io limit inclusive");
        send(1'b0, 2'd0, 32'h0000_0FFF, "R4 io below base");
        send(1'b0, 2'd0, 32'h0000_2000, "R4 io above limit");
        send(1'b0, 2'd1, 32'h8000_0000, "R5 mem in window");
        send(1'b0, 2'd2, 32'h8000_0000, "R5 pf in mem window only");
        send(1'b0, 2'd2, 32'hCFFF_FFFF, "R5 pf at limit");
        send(1'b0, 2'd1, 32'h9000_0000, "R5 mem past limit");
        idle();

        // R6 secondary
        send(1'b1, 2'd0, 32'h0000_1000, "R6 sec io inside");
        send(1'b1, 2'd0, 32'h0000_3000, "R6 sec io outside");
        send(1'b1, 2'd1, 32'h8500_0000, "R6 sec mem inside mem");
        send(1'b1, 2'd1, 32'hC000_0000, "R6 sec mem inside pf");
        send(1'b1, 2'd1, 32'h4000_0000, "R6 sec mem outside");
        send(1'b1, 2'd2, 32'h9000_0000, "R6 sec pf outside");
        idle();

        // R11 reserved class
        send(1'b0, 2'd3, 32'h0000_1800, "R11 pri rsvd");
        send(1'b1, 2'd3, 32'h0000_3000, "R11 sec rsvd");
        idle();

        // R7, R8 with master only
        cfg_write(3'd0, 32'h0000_0004);
        send(1'b0, 2'd0, 32'h0000_1800, "R7 io disabled");
        send(1'b0, 2'd1, 32'h8000_1000, "R8 mem disabled");
        send(1'b0, 2'd2, 32'hC000_1000, "R8 pf disabled");
        send(1'b1, 2'd0, 32'h0000_5000, "R9 master on io up");
        idle();

        // R9 master clear
        cfg_write(3'd0, 32'h0000_0003);
        send(1'b1, 2'd0, 32'h0000_5000, "R9 sec io ignored");
        send(1'b1, 2'd1, 32'h4000_0000, "R9 sec mem ignored");
        send(1'b0, 2'd0, 32'h0000_1800, "R7 io enabled");
        idle();

        // R4 inverted window
        cfg_write(3'd0, 32'h0000_0007);
        cfg_write(3'd1, 32'h0000_2000);
        send(1'b0, 2'd0, 32'h0000_1FFF, "R4 inverted pri");
        send(1'b0, 2'd0, 32'h0000_2000, "R4 inverted pri base");
        send(1'b1, 2'd0, 32'h0000_1FFF, "R4 inverted sec up");
        idle();

        // R10 same-cycle write uses old values
        write_and_send(3'd0, 32'h0000_0000, 1'b0, 2'd1, 32'h8123_4567, "R10 old cmd used");
        send(1'b0, 2'd1, 32'h8123_4567, "R10 new cmd applied");
        idle();

        repeat (3) @(negedge clk);
        check("R2 queue drained", q.size(), 32'd0);
        check("R2 response count", seen, pushed);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule